// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges every reason a small microcontroller may need to restart into one system reset. Five causes feed it: an active-low external reset pin, a watchdog overflow strobe, a power-on-clear flag, a low-voltage detector flag, and an illegal-opcode strobe from the instruction decoder. Each cause has its own release rule. The pin must stay low for a minimum number of cycles before it counts as a reset, and it holds reset for as long as it stays low. The watchdog and illegal-opcode causes release on their own. The two supply causes wait until their "supply good" input is true.

Every cause is followed by a fixed processing interval before reset is released. A new cause that arrives inside that interval starts the interval again. When reset is released, the block pulses a request to fetch the start address from the two-byte reset vector at address zero. While reset is active, the block places the port pins in high impedance, except one pin that it drives low. It also stops all oscillators and gates off the external main clock. After release, only the internal high-speed oscillator runs.

A sticky cause register records watchdog, low-voltage and illegal-opcode resets. Software can read it and clear it. The power-on-clear flag is the block's own asynchronous reset. Reset is therefore asserted at once by that flag and released only on a clock edge.

Top module: `mcu_rst_ctrl`

## Requirements
- R1: Every cause and qualifier input passes through two synchronizer flops. A one-cycle watchdog strobe applied between clock edges raises `sys_rst` at the third rising edge that follows it.
- R2: A low level on `ext_rst_n` that lasts fewer than FILT_CYC synchronized cycles is ignored. A low level that lasts FILT_CYC cycles or more asserts reset, which holds while the pin stays low. Release begins only after the pin returns high and completes PROC_CYC+3 cycles after the pin rises.
- R3: While `vdd_in_range` is low, the pin filter count neither advances nor clears. Counts taken before and after an out-of-range stretch add together.
- R4: A `bad_opcode` strobe causes a reset and sets its cause bit only while `debug_mode` is low. While `debug_mode` is high, the strobe changes neither `sys_rst` nor `cause`.
- R5: A one-cycle watchdog strobe keeps `sys_rst` high for exactly PROC_CYC cycles. `vec_req` pulses high for exactly one cycle, in the first cycle after release.
- R6: `pwr_on_det` high asserts `sys_rst` at once, without a clock edge, and clears `cause`. Reset then holds until `por_vdd_ok` is high. It releases PROC_CYC+3 cycles after `por_vdd_ok` rises.
- R7: `brownout_det` asserts reset. Reset holds until `brownout_det` is low and `brn_vdd_ok` is high. It releases PROC_CYC+3 cycles after the later of these two conditions is met.
- R8: A cause that arrives while the processing interval is running restarts the interval. Release comes PROC_CYC+3 cycles after the last strobe.
- R9: While `sys_rst` is high, `port_hiz` is all ones except bit LOWPIN_IDX, which is 0, and `pin_low_drv` is 1. After release, `port_hiz` is all zeros and `pin_low_drv` is 0.
- R10: While `sys_rst` is high, `osc_stop` is all ones and `ext_clk_gate` is 1. After release, only bit HS_OSC_IDX (the internal high-speed oscillator) of `osc_stop` is 0, and `ext_clk_gate` is 0.
- R11: The `cause` bits are sticky: bit 0 records a watchdog reset, bit 1 a low-voltage reset, and bit 2 an illegal-opcode reset. A `cause_clr` pulse clears all three bits. If a cause is set in the same cycle as `cause_clr`, the new bit survives and the other bits clear.
- R12: A qualified external pin reset clears the whole `cause` register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdog_expire | input | 1 | Watchdog overflow strobe |
| pwr_on_det | input | 1 | Power-on-clear flag; asynchronous reset of the block |
| brownout_det | input | 1 | Low-voltage detector flag |
| bad_opcode | input | 1 | Decoder strobe: an illegal opcode was executed |
| debug_mode | input | 1 | While high, illegal-opcode strobes are ignored |
| por_vdd_ok | input | 1 | Supply is at or above the power-on-clear threshold |
| brn_vdd_ok | input | 1 | Supply is at or above the low-voltage threshold |
| vdd_in_range | input | 1 | Supply is inside the operating range; enables the pin filter |
| cause_clr | input | 1 | Synchronous pulse that clears the cause register |
| sys_rst | output | 1 | System reset, active high |
| vec_req | output | 1 | One-cycle request to fetch the reset vector word at address zero |
| cause | output | 3 | Sticky cause bits: watchdog, low-voltage, illegal opcode |
| port_hiz | output | NPORT | Per-pin high-impedance select |
| pin_low_drv | output | 1 | Drives the dedicated pin low during reset |
| osc_stop | output | NOSC | Per-oscillator stop request |
| ext_clk_gate | output | 1 | Gates off the external main clock input |

## Verification
The cause register can be written by software and by a new cause in the same clock edge. A `cause_clr` pulse may land in the same cycle that a synchronized watchdog strobe sets bit 0. The bench provokes this with an illegal-opcode bit already recorded. It drives a watchdog strobe and raises `cause_clr` exactly two cycles later, so that `cause_clr` covers the edge at which the strobe emerges from the synchronizer. The expected value is 3'b001: the old illegal-opcode bit is cleared and the new watchdog bit is kept. A second overlap is also covered: a watchdog strobe that arrives during the processing interval of an earlier one must move the release time by the full interval.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    // cause register bit positions
    localparam int NCAUSE  = 3;
    localparam int CZ_WDOG = 0;
    localparam int CZ_BRN  = 1;
    localparam int CZ_BAD  = 2;

    // synchronizer lane positions
    localparam int NSYNC    = 8;
    localparam int SY_PIN   = 0;
    localparam int SY_WDOG  = 1;
    localparam int SY_BRN   = 2;
    localparam int SY_BAD   = 3;
    localparam int SY_DBG   = 4;
    localparam int SY_PORK  = 5;
    localparam int SY_BRNOK = 6;
    localparam int SY_RANGE = 7;

    // pin idles high, every other lane idles low
    localparam logic [NSYNC-1:0] SYNC_IDLE = 8'b0000_0001;

    typedef struct packed {
        logic ext_low;
        logic wdog;
        logic brn_det;
        logic bad_op;
        logic por_ok;
        logic brn_ok;
    } cause_req_t;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         arst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_lane
        logic meta_q, out_q;
        always_ff @(posedge clk or posedge arst) begin
            if (arst) begin
                meta_q <= RST_VAL[i];
                out_q  <= RST_VAL[i];
            end else begin
                meta_q <= d[i];
                out_q  <= meta_q;
            end
        end
        assign q[i] = out_q;
    end
endmodule

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
    parameter int FILT_CYC = 200
) (
    input  logic clk,
    input  logic arst,
    input  logic pin_n_s,
    input  logic range_ok_s,
    output logic ext_low
);
    localparam int CW = $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic          low;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pin_n_s) begin
            st_d.cnt = '0;
            st_d.low = 1'b0;
        end else if (range_ok_s && !st_q.low) begin
            if (st_q.cnt == CW'(FILT_CYC - 1)) st_d.low = 1'b1;
            else                               st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) st_q <= '0;
        else      st_q <= st_d;
    end

    assign ext_low = st_q.low;
endmodule

// File: rtl/rstc_seq.sv
module rstc_seq
    import rstc_pkg::*;
#(
    parameter int PROC_CYC = 64
) (
    input  logic              clk,
    input  logic              arst,
    input  cause_req_t        req,
    input  logic              cause_clr,
    output logic              rst,
    output logic              vreq,
    output logic [NCAUSE-1:0] cause
);
    localparam int CW = $clog2(PROC_CYC + 1);

    typedef struct packed {
        logic              rst;
        logic              vreq;
        logic              por_wait;
        logic              brn_wait;
        logic [CW-1:0]     cnt;
        logic [NCAUSE-1:0] cause;
    } seq_t;

    localparam seq_t SEQ_RST = '{rst: 1'b1, vreq: 1'b0, por_wait: 1'b1,
                                 brn_wait: 1'b0, cnt: '0, cause: '0};

    seq_t st_d, st_q;
    logic active;

    always_comb begin
        st_d      = st_q;
        st_d.vreq = 1'b0;

        if (req.brn_det)     st_d.brn_wait = 1'b1;
        else if (req.brn_ok) st_d.brn_wait = 1'b0;
        if (req.por_ok)      st_d.por_wait = 1'b0;

        active = st_q.por_wait | st_q.brn_wait | req.brn_det |
                 req.ext_low | req.wdog | req.bad_op;

        if (active) begin
            st_d.rst = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.rst) begin
            if (st_q.cnt == CW'(PROC_CYC - 1)) begin
                st_d.rst  = 1'b0;
                st_d.cnt  = '0;
                st_d.vreq = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        // clears first, new causes win
        if (req.ext_low || cause_clr) st_d.cause = '0;
        if (req.wdog)    st_d.cause[CZ_WDOG] = 1'b1;
        if (req.brn_det) st_d.cause[CZ_BRN]  = 1'b1;
        if (req.bad_op)  st_d.cause[CZ_BAD]  = 1'b1;
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) st_q <= SEQ_RST;
        else      st_q <= st_d;
    end

    assign rst   = st_q.rst;
    assign vreq  = st_q.vreq;
    assign cause = st_q.cause;
endmodule

// File: rtl/mcu_rst_ctrl.sv
module mcu_rst_ctrl
    import rstc_pkg::*;
#(
    parameter int FILT_CYC   = 200,
    parameter int PROC_CYC   = 64,
    parameter int NPORT      = 16,
    parameter int LOWPIN_IDX = 15,
    parameter int NOSC       = 4,
    parameter int HS_OSC_IDX = 0
) (
    input  logic              clk,
    input  logic              ext_rst_n,
    input  logic              wdog_expire,
    input  logic              pwr_on_det,
    input  logic              brownout_det,
    input  logic              bad_opcode,
    input  logic              debug_mode,
    input  logic              por_vdd_ok,
    input  logic              brn_vdd_ok,
    input  logic              vdd_in_range,
    input  logic              cause_clr,
    output logic              sys_rst,
    output logic              vec_req,
    output logic [NCAUSE-1:0] cause,
    output logic [NPORT-1:0]  port_hiz,
    output logic              pin_low_drv,
    output logic [NOSC-1:0]   osc_stop,
    output logic              ext_clk_gate
);
    logic [NSYNC-1:0] raw, syn;
    logic             ext_low;
    cause_req_t       req;

    always_comb begin
        raw           = '0;
        raw[SY_PIN]   = ext_rst_n;
        raw[SY_WDOG]  = wdog_expire;
        raw[SY_BRN]   = brownout_det;
        raw[SY_BAD]   = bad_opcode;
        raw[SY_DBG]   = debug_mode;
        raw[SY_PORK]  = por_vdd_ok;
        raw[SY_BRNOK] = brn_vdd_ok;
        raw[SY_RANGE] = vdd_in_range;
    end

    rstc_sync #(.W(NSYNC), .RST_VAL(SYNC_IDLE)) u_sync (
        .clk (clk),
        .arst(pwr_on_det),
        .d   (raw),
        .q   (syn)
    );

    rstc_pin_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk       (clk),
        .arst      (pwr_on_det),
        .pin_n_s   (syn[SY_PIN]),
        .range_ok_s(syn[SY_RANGE]),
        .ext_low   (ext_low)
    );

    always_comb begin
        req.ext_low = ext_low;
        req.wdog    = syn[SY_WDOG];
        req.brn_det = syn[SY_BRN];
        req.bad_op  = syn[SY_BAD] & ~syn[SY_DBG];
        req.por_ok  = syn[SY_PORK];
        req.brn_ok  = syn[SY_BRNOK];
    end

    rstc_seq #(.PROC_CYC(PROC_CYC)) u_seq (
        .clk      (clk),
        .arst     (pwr_on_det),
        .req      (req),
        .cause_clr(cause_clr),
        .rst      (sys_rst),
        .vreq     (vec_req),
        .cause    (cause)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        if (p == LOWPIN_IDX) begin : g_low
            assign port_hiz[p] = 1'b0;
        end else begin : g_hiz
            assign port_hiz[p] = sys_rst;
        end
    end
    assign pin_low_drv = sys_rst;

    for (genvar o = 0; o < NOSC; o++) begin : g_osc
        if (o == HS_OSC_IDX) begin : g_hs
            assign osc_stop[o] = sys_rst;
        end else begin : g_other
            assign osc_stop[o] = 1'b1;
        end
    end
    assign ext_clk_gate = sys_rst;
endmodule

// File: rtl/mcu_rst_ctrl_chk.sv
module mcu_rst_ctrl_chk #(
    parameter int NPORT      = 16,
    parameter int LOWPIN_IDX = 15,
    parameter int NOSC       = 4
) (
    input logic             clk,
    input logic             pwr_on_det,
    input logic             sys_rst,
    input logic             vec_req,
    input logic [2:0]       cause,
    input logic [NPORT-1:0] port_hiz,
    input logic             pin_low_drv,
    input logic [NOSC-1:0]  osc_stop,
    input logic             ext_clk_gate
);
    // R9
    port_hiz_chk: assert property (@(posedge clk) disable iff (pwr_on_det)
        sys_rst |-> (!port_hiz[LOWPIN_IDX] && pin_low_drv &&
                     $countones(port_hiz) == NPORT - 1));

    // R10
    clk_stop_chk: assert property (@(posedge clk) disable iff (pwr_on_det)
        sys_rst |-> ((&osc_stop) && ext_clk_gate));

    // R5
    vec_once_chk: assert property (@(posedge clk) disable iff (pwr_on_det)
        vec_req |=> !vec_req);

    // R5
    vec_release_chk: assert property (@(posedge clk) disable iff (pwr_on_det)
        vec_req |-> (!sys_rst && $past(sys_rst)));

    // R11
    cause_in_rst_chk: assert property (@(posedge clk) disable iff (pwr_on_det)
        $rose(cause[0]) |-> sys_rst);
endmodule

bind mcu_rst_ctrl mcu_rst_ctrl_chk #(
    .NPORT(NPORT), .LOWPIN_IDX(LOWPIN_IDX), .NOSC(NOSC)
) u_chk (
    .clk         (clk),
    .pwr_on_det  (pwr_on_det),
    .sys_rst     (sys_rst),
    .vec_req     (vec_req),
    .cause       (cause),
    .port_hiz    (port_hiz),
    .pin_low_drv (pin_low_drv),
    .osc_stop    (osc_stop),
    .ext_clk_gate(ext_clk_gate)
);

// File: tb/mcu_rst_ctrl_tb.sv
module mcu_rst_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FILT  = 12;
    localparam int PROC  = 20;
    localparam int NPORT = 16;
    localparam int LOWP  = 15;
    localparam int NOSC  = 4;
    localparam int HS    = 0;

    logic clk = 1'b0;
    logic ext_rst_n, wdog_expire, pwr_on_det, brownout_det, bad_opcode;
    logic debug_mode, por_vdd_ok, brn_vdd_ok, vdd_in_range, cause_clr;
    logic sys_rst, vec_req, pin_low_drv, ext_clk_gate;
    logic [2:0] cause;
    logic [NPORT-1:0] port_hiz;
    logic [NOSC-1:0] osc_stop;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mcu_rst_ctrl #(
        .FILT_CYC(FILT), .PROC_CYC(PROC), .NPORT(NPORT),
        .LOWPIN_IDX(LOWP), .NOSC(NOSC), .HS_OSC_IDX(HS)
    ) u_dut (
        .clk(clk), .ext_rst_n(ext_rst_n), .wdog_expire(wdog_expire),
        .pwr_on_det(pwr_on_det), .brownout_det(brownout_det),
        .bad_opcode(bad_opcode), .debug_mode(debug_mode),
        .por_vdd_ok(por_vdd_ok), .brn_vdd_ok(brn_vdd_ok),
        .vdd_in_range(vdd_in_range), .cause_clr(cause_clr),
        .sys_rst(sys_rst), .vec_req(vec_req), .cause(cause),
        .port_hiz(port_hiz), .pin_low_drv(pin_low_drv),
        .osc_stop(osc_stop), .ext_clk_gate(ext_clk_gate)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // ticks until sys_rst equals lvl
    task automatic ticks_until(input logic lvl, output int n);
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            tick();
            n++;
            if (sys_rst === lvl) break;
        end
    endtask

    function automatic logic [NPORT-1:0] hiz_on();
        logic [NPORT-1:0] v;
        v = '1;
        v[LOWP] = 1'b0;
        return v;
    endfunction

    function automatic logic [NOSC-1:0] osc_run();
        logic [NOSC-1:0] v;
        v = '1;
        v[HS] = 1'b0;
        return v;
    endfunction

    task automatic check_in_reset(input string tag);
        chk({tag, " R9 port_hiz"}, 32'(port_hiz), 32'(hiz_on()));
        chk({tag, " R9 pin_low_drv"}, 32'(pin_low_drv), 1);
        chk({tag, " R10 osc_stop"}, 32'(osc_stop), 32'({NOSC{1'b1}}));
        chk({tag, " R10 ext_clk_gate"}, 32'(ext_clk_gate), 1);
    endtask

    task automatic check_released(input string tag);
        chk({tag, " R9 port_hiz"}, 32'(port_hiz), 0);
        chk({tag, " R9 pin_low_drv"}, 32'(pin_low_drv), 0);
        chk({tag, " R10 osc_stop"}, 32'(osc_stop), 32'(osc_run()));
        chk({tag, " R10 ext_clk_gate"}, 32'(ext_clk_gate), 0);
    endtask

    task automatic t_power_on();
        int n;
        pwr_on_det = 1'b1;
        #1;
        chk("R6 async assert at time zero", 32'(sys_rst), 1);
        repeat (3) tick();
        chk("R6 cause cleared", 32'(cause), 0);
        chk("R5 no vec_req in reset", 32'(vec_req), 0);
        check_in_reset("por");
        pwr_on_det = 1'b0;
        repeat (30) tick();
        chk("R6 held without supply ok", 32'(sys_rst), 1);
        por_vdd_ok = 1'b1;
        ticks_until(1'b0, n);
        chk("R6 release latency", n, PROC + 3);
        chk("R5 vec_req at release", 32'(vec_req), 1);
        check_released("por");
        tick();
        chk("R5 vec_req single cycle", 32'(vec_req), 0);
    endtask

    task automatic t_watchdog();
        int n;
        wdog_expire = 1'b1;
        tick();
        wdog_expire = 1'b0;
        ticks_until(1'b1, n);
        chk("R1 sync latency", n + 1, 3);
        chk("R11 watchdog cause bit", 32'(cause), 3'b001);
        check_in_reset("wdog");
        ticks_until(1'b0, n);
        chk("R5 processing length", n, PROC);
        chk("R5 vec_req after watchdog", 32'(vec_req), 1);
    endtask

    task automatic t_restart();
        int n;
        wdog_expire = 1'b1;
        tick();
        wdog_expire = 1'b0;
        repeat (7) tick();
        wdog_expire = 1'b1;
        tick();
        wdog_expire = 1'b0;
        ticks_until(1'b0, n);
        chk("R8 restart of interval", n + 9, 8 + 3 + PROC);
    endtask

    task automatic t_bad_opcode();
        int n;
        logic seen;
        debug_mode = 1'b1;
        tick();
        bad_opcode = 1'b1;
        tick();
        bad_opcode = 1'b0;
        seen = 1'b0;
        repeat (10) begin
            tick();
            if (sys_rst) seen = 1'b1;
        end
        chk("R4 debug ignores opcode reset", 32'(seen), 0);
        chk("R4 debug leaves cause", 32'(cause), 3'b001);
        debug_mode = 1'b0;
        repeat (3) tick();
        bad_opcode = 1'b1;
        tick();
        bad_opcode = 1'b0;
        ticks_until(1'b1, n);
        chk("R4 opcode reset latency", n + 1, 3);
        chk("R4 opcode cause bit", 32'(cause), 3'b101);
        ticks_until(1'b0, n);
        chk("R4 opcode auto release", n, PROC);
    endtask

    task automatic t_clear_collide();
        // cause holds 3'b101 here
        wdog_expire = 1'b1;
        tick();
        wdog_expire = 1'b0;
        tick();
        cause_clr = 1'b1;
        tick();
        cause_clr = 1'b0;
        chk("R11 set wins over clear", 32'(cause), 3'b001);
        begin
            int n;
            ticks_until(1'b0, n);
        end
        cause_clr = 1'b1;
        tick();
        cause_clr = 1'b0;
        chk("R11 clear alone", 32'(cause), 0);
    endtask

    task automatic t_brownout();
        int n;
        brn_vdd_ok = 1'b0;
        brownout_det = 1'b1;
        repeat (6) tick();
        brownout_det = 1'b0;
        repeat (PROC * 2) tick();
        chk("R7 held until supply ok", 32'(sys_rst), 1);
        chk("R11 low-voltage cause bit", 32'(cause), 3'b010);
        brn_vdd_ok = 1'b1;
        ticks_until(1'b0, n);
        chk("R7 release latency", n, PROC + 3);
    endtask

    task automatic t_ext_pin();
        int n;
        logic seen;
        ext_rst_n = 1'b0;
        repeat (FILT - 1) tick();
        ext_rst_n = 1'b1;
        seen = 1'b0;
        repeat (30) begin
            tick();
            if (sys_rst) seen = 1'b1;
        end
        chk("R2 short pulse ignored", 32'(seen), 0);
        ext_rst_n = 1'b0;
        ticks_until(1'b1, n);
        chk("R2 qualified latency", n, FILT + 3);
        chk("R12 pin reset clears cause", 32'(cause), 0);
        check_in_reset("pin");
        repeat (PROC * 2) tick();
        chk("R2 held while low", 32'(sys_rst), 1);
        ext_rst_n = 1'b1;
        ticks_until(1'b0, n);
        chk("R2 release after high", n, PROC + 3);
        check_released("pin");
    endtask

    task automatic t_range();
        int n;
        logic seen;
        vdd_in_range = 1'b0;
        ext_rst_n = 1'b0;
        seen = 1'b0;
        repeat (FILT + 10) begin
            tick();
            if (sys_rst) seen = 1'b1;
        end
        ext_rst_n = 1'b1;
        vdd_in_range = 1'b1;
        repeat (10) begin
            tick();
            if (sys_rst) seen = 1'b1;
        end
        chk("R3 filter frozen out of range", 32'(seen), 0);
        ext_rst_n = 1'b0;
        repeat (FILT / 2) tick();
        vdd_in_range = 1'b0;
        repeat (20) begin
            tick();
            if (sys_rst) seen = 1'b1;
        end
        chk("R3 no reset while frozen", 32'(seen), 0);
        vdd_in_range = 1'b1;
        ticks_until(1'b1, n);
        chk("R3 count held across gap", n, FILT / 2 + 3);
        ext_rst_n = 1'b1;
        ticks_until(1'b0, n);
    endtask

    task automatic t_async_por();
        int n;
        tick();
        #2;
        pwr_on_det = 1'b1;
        #1;
        chk("R6 async assert mid-cycle", 32'(sys_rst), 1);
        tick();
        pwr_on_det = 1'b0;
        por_vdd_ok = 1'b0;
        repeat (5) tick();
        por_vdd_ok = 1'b1;
        ticks_until(1'b0, n);
        chk("R6 second release", n, PROC + 3);
    endtask

    initial begin
        ext_rst_n = 1'b1; wdog_expire = 1'b0; brownout_det = 1'b0;
        bad_opcode = 1'b0; debug_mode = 1'b0; por_vdd_ok = 1'b0;
        brn_vdd_ok = 1'b1; vdd_in_range = 1'b1; cause_clr = 1'b0;
        pwr_on_det = 1'b1;
        t_power_on();
        t_watchdog();
        t_restart();
        t_bad_opcode();
        t_clear_collide();
        t_brownout();
        t_ext_pin();
        t_range();
        t_async_por();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule